// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block runs one programmed-I/O read or write on an IDE drive bus for each host request it accepts. A request names one of four drives and a direction. The block reads that drive's timing bytes and runs three phases back to back. The first is an address setup phase with both strobes high. The second is an active phase, where the read strobe or the write strobe is held low. The third is a recovery phase with both strobes high again. After recovery it pulses a one-clock completion flag and is ready for the next request.

The length of each phase comes from encoded timing bytes. The setup length is a two-bit code in the top of a per-drive address-timing byte. The active and recovery lengths are two nibbles in a per-drive strobe-timing byte. Drives 0 and 1 each have their own pair of bytes. Drives 2 and 3 share one pair.

A silicon revision input selects whether recovery gets one extra clock. On a read, the block captures the drive data bus on the last active clock. On a write, it drives the write data for the whole cycle.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: The setup phase length is decoded from bits 7:6 of the selected address-timing byte: 2'b00 gives 4 clocks, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5.
- R2: The active phase length is the upper nibble (bits 7:4) of the selected strobe-timing byte. A nibble of 0 means 16 clocks.
- R3: The active phase is at least 2 clocks long, so an active nibble of 1 runs for 2 clocks.
- R4: The recovery length is the lower nibble (bits 3:0) of the strobe-timing byte, and a nibble of 0 means 16 clocks. When the active length is above 3 and the recovery nibble is 1, recovery is 2 clocks.
- R5: When `silicon_rev` is 2 or more, recovery lasts one clock longer than the length given by R4. Revisions 0 and 1 add nothing.
- R6: Drive 0 uses `setup_tim0`/`rw_tim0` and drive 1 uses `setup_tim1`/`rw_tim1`. Drives 2 and 3 both use `setup_tim23`/`rw_tim23`.
- R7: Phases run strictly in the order setup, active, recovery. `req_ready` is high only while idle, and `req_valid` is ignored while busy. `done` is high for exactly one clock, in the cycle right after the last recovery clock, and a new request may be accepted in that cycle.
- R8: On a read (`req_write`=0), only `dior_n` goes low. `rd_latch` is high on the last active clock only, and `rd_data` then holds the `dd_in` value from that clock.
- R9: On a write (`req_write`=1), only `diow_n` goes low. `wr_oe` is high from the first setup clock through the last recovery clock, with `wr_data` equal to the request data. `wr_oe` is low at all other times.
- R10: Bits 5:0 of the address-timing bytes have no effect on any phase length.
- R11: After synchronous reset, both strobes are high, `wr_oe`, `rd_latch` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a bus cycle |
| req_drive | input | 2 | Drive index 0..3 |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wdata | input | DATA_W | Write data for the request |
| req_ready | output | 1 | Idle; a request is accepted at the next edge |
| setup_tim0 | input | 8 | Address-timing byte, drive 0 (bits 7:6 used) |
| setup_tim1 | input | 8 | Address-timing byte, drive 1 |
| setup_tim23 | input | 8 | Address-timing byte shared by drives 2 and 3 |
| rw_tim0 | input | 8 | Strobe-timing byte, drive 0 (active/recovery nibbles) |
| rw_tim1 | input | 8 | Strobe-timing byte, drive 1 |
| rw_tim23 | input | 8 | Strobe-timing byte shared by drives 2 and 3 |
| silicon_rev | input | 2 | Revision code; 2 or more adds a recovery clock |
| dd_in | input | DATA_W | Drive data bus input |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| rd_latch | output | 1 | Read data capture enable, last active clock |
| rd_data | output | DATA_W | Captured read data |
| wr_oe | output | 1 | Write data output enable |
| wr_data | output | DATA_W | Write data toward the drive bus |
| done | output | 1 | One-clock completion pulse |

## Verification
A request seen at a rising edge puts the block in setup in the very next clock interval. The strobe falls S intervals later and stays low for A intervals. Recovery then lasts R intervals, and `done` appears in the interval after that, together with a valid `rd_data`.

The bench samples every output at the falling edge. It counts the intervals in each phase directly from the strobes and `req_ready`, and records `dd_in` in the last strobe-low interval. When `done` appears, it compares those counts and values against the queued expectation, so no check depends on guessing an absolute cycle number.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;

    localparam int CNT_W = 5;   // holds lengths up to 17
    localparam int TIM_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    // Timing bytes for one drive
    typedef struct packed {
        logic [TIM_W-1:0] addr_byte;    // setup code in [7:6]
        logic [TIM_W-1:0] strobe_byte;  // active [7:4], recovery [3:0]
    } drv_tim_t;

    // Decoded phase lengths in clocks
    typedef struct packed {
        cnt_t setup_len;
        cnt_t act_len;
        cnt_t rec_len;
    } phase_len_t;

    localparam cnt_t ACT_MIN      = cnt_t'(2);
    localparam cnt_t BUMP_ACT_GT  = cnt_t'(3);
    localparam cnt_t BUMP_REC_LEN = cnt_t'(2);

    function automatic cnt_t setup_code_len(input logic [1:0] code);
        case (code)
            2'b00:   return cnt_t'(4);
            2'b10:   return cnt_t'(3);
            2'b01:   return cnt_t'(2);
            default: return cnt_t'(5);
        endcase
    endfunction

    function automatic cnt_t nibble_len(input logic [3:0] nib);
        return (nib == 4'd0) ? cnt_t'(16) : cnt_t'(nib);
    endfunction

endpackage

// File: rtl/pio_drive_sel.sv
module pio_drive_sel
    import pio_tim_pkg::*;
#(
    parameter int DRV_W = 2
) (
    input  logic [DRV_W-1:0] drive,
    input  drv_tim_t         tim_d0,
    input  drv_tim_t         tim_d1,
    input  drv_tim_t         tim_shared,
    output drv_tim_t         tim_sel
);

    localparam logic [DRV_W-1:0] DRV0 = DRV_W'(0);
    localparam logic [DRV_W-1:0] DRV1 = DRV_W'(1);

    always_comb begin
        if (drive == DRV0)
            tim_sel = tim_d0;
        else if (drive == DRV1)
            tim_sel = tim_d1;
        else
            tim_sel = tim_shared;
    end

endmodule

// File: rtl/pio_len_decode.sv
module pio_len_decode
    import pio_tim_pkg::*;
#(
    parameter int REV_W        = 2,
    parameter int LATE_REV_MIN = 2
) (
    input  drv_tim_t         tim,
    input  logic [REV_W-1:0] rev,
    output phase_len_t       len
);

    localparam logic [REV_W-1:0] LATE_REV = REV_W'(LATE_REV_MIN);

    logic [3:0] act_nib;
    logic [3:0] rec_nib;
    cnt_t       act_raw;
    cnt_t       act_len;
    cnt_t       rec_base;
    logic       late_rev;

    // Only the setup code bits matter; the rest of the byte is dropped
    logic unused_addr_low;
    assign unused_addr_low = ^tim.addr_byte[TIM_W-3:0];

    assign act_nib  = tim.strobe_byte[7:4];
    assign rec_nib  = tim.strobe_byte[3:0];
    assign late_rev = (rev >= LATE_REV);

    always_comb begin
        act_raw = nibble_len(act_nib);
        act_len = (act_raw < ACT_MIN) ? ACT_MIN : act_raw;

        rec_base = nibble_len(rec_nib);
        if (act_len > BUMP_ACT_GT && rec_nib == 4'd1)
            rec_base = BUMP_REC_LEN;

        len.setup_len = setup_code_len(tim.addr_byte[TIM_W-1:TIM_W-2]);
        len.act_len   = act_len;
        len.rec_len   = late_rev ? rec_base + cnt_t'(1) : rec_base;
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_tim_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_len_t        len_in,
    input  logic [DATA_W-1:0] dd_in,
    output logic              req_ready,
    output logic              dior_n,
    output logic              diow_n,
    output logic              rd_latch,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_oe,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    phase_e            state_q;
    cnt_t              cnt_q;
    phase_len_t        len_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              last_clk;

    assign last_clk = (cnt_q == cnt_t'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        len_q   <= len_in;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        cnt_q   <= len_in.setup_len - cnt_t'(1);
                        state_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        cnt_q   <= len_q.act_len - cnt_t'(1);
                        state_q <= PH_ACTIVE;
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (last_clk) begin
                        if (!write_q)
                            rdata_q <= dd_in;
                        cnt_q   <= len_q.rec_len - cnt_t'(1);
                        state_q <= PH_RECOV;
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                default: begin
                    if (last_clk) begin
                        done_q  <= 1'b1;
                        state_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
            endcase
        end
    end

    assign req_ready = (state_q == PH_IDLE);
    assign dior_n    = !((state_q == PH_ACTIVE) && !write_q);
    assign diow_n    = !((state_q == PH_ACTIVE) && write_q);
    assign rd_latch  = (state_q == PH_ACTIVE) && !write_q && last_clk;
    assign rd_data   = rdata_q;
    assign wr_oe     = write_q && (state_q != PH_IDLE);
    assign wr_data   = wdata_q;
    assign done      = done_q;

    // Length of the current strobe-low run, for the checks below
    logic strobe_low;
    cnt_t chk_run_q;
    assign strobe_low = !dior_n || !diow_n;

    always_ff @(posedge clk) begin
        if (rst)
            chk_run_q <= '0;
        else
            chk_run_q <= strobe_low ? chk_run_q + cnt_t'(1) : '0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_RECOV: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state_q) == PH_RECOV); // R7

    AST_SETUP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_SETUP && $past(state_q) == PH_IDLE)
            |-> (len_q.setup_len >= cnt_t'(2) && len_q.setup_len <= cnt_t'(5))); // R1

    AST_ACTIVE_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_low) |-> (chk_run_q >= ACT_MIN && chk_run_q <= cnt_t'(16))); // R3

    AST_LATCH_LAST: assert property (@(posedge clk) disable iff (rst)
        rd_latch |=> dior_n); // R8

    AST_OE_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_oe) |-> done); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!dior_n, !diow_n})); // R8

endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import pio_tim_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int REV_W        = 2,
    parameter int LATE_REV_MIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_drive,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic [7:0]        setup_tim0,
    input  logic [7:0]        setup_tim1,
    input  logic [7:0]        setup_tim23,
    input  logic [7:0]        rw_tim0,
    input  logic [7:0]        rw_tim1,
    input  logic [7:0]        rw_tim23,
    input  logic [REV_W-1:0]  silicon_rev,
    input  logic [DATA_W-1:0] dd_in,
    output logic              dior_n,
    output logic              diow_n,
    output logic              rd_latch,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_oe,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    drv_tim_t   tim_d0;
    drv_tim_t   tim_d1;
    drv_tim_t   tim_shared;
    drv_tim_t   tim_sel;
    phase_len_t len_sel;

    assign tim_d0     = '{addr_byte: setup_tim0,  strobe_byte: rw_tim0};
    assign tim_d1     = '{addr_byte: setup_tim1,  strobe_byte: rw_tim1};
    assign tim_shared = '{addr_byte: setup_tim23, strobe_byte: rw_tim23};

    pio_drive_sel #(
        .DRV_W (2)
    ) u_sel (
        .drive      (req_drive),
        .tim_d0     (tim_d0),
        .tim_d1     (tim_d1),
        .tim_shared (tim_shared),
        .tim_sel    (tim_sel)
    );

    pio_len_decode #(
        .REV_W        (REV_W),
        .LATE_REV_MIN (LATE_REV_MIN)
    ) u_dec (
        .tim (tim_sel),
        .rev (silicon_rev),
        .len (len_sel)
    );

    pio_phase_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .len_in    (len_sel),
        .dd_in     (dd_in),
        .req_ready (req_ready),
        .dior_n    (dior_n),
        .diow_n    (diow_n),
        .rd_latch  (rd_latch),
        .rd_data   (rd_data),
        .wr_oe     (wr_oe),
        .wr_data   (wr_data),
        .done      (done)
    );

endmodule

// File: tb/ide_pio_strobe_gen_bench.sv
module ide_pio_strobe_gen_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_drive = 2'd0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [7:0]    st0 = 8'h00, st1 = 8'h00, st23 = 8'h00;
    logic [7:0]    rw0 = 8'h00, rw1 = 8'h00, rw23 = 8'h00;
    logic [1:0]    rev = 2'd1;
    logic [DW-1:0] dd_in = '0;
    logic          req_ready, dior_n, diow_n, rd_latch, wr_oe, done;
    logic [DW-1:0] rd_data, wr_data;

    always #4 clk = ~clk;   // 125 MHz

    ide_pio_strobe_gen u_ide_pio_strobe_gen (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_drive   (req_drive),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .setup_tim0  (st0),
        .setup_tim1  (st1),
        .setup_tim23 (st23),
        .rw_tim0     (rw0),
        .rw_tim1     (rw1),
        .rw_tim23    (rw23),
        .silicon_rev (rev),
        .dd_in       (dd_in),
        .dior_n      (dior_n),
        .diow_n      (diow_n),
        .rd_latch    (rd_latch),
        .rd_data     (rd_data),
        .wr_oe       (wr_oe),
        .wr_data     (wr_data),
        .done        (done)
    );

    // Data bus changes every clock, so the capture clock is visible
    always @(posedge clk) dd_in <= dd_in + 16'h1357;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    typedef struct {
        int s;
        int a;
        int r;
        bit wr;
        int wd;
        int id;
    } exp_t;

    exp_t exp_q[$];
    int   next_id = 0;

    function automatic int b_setup(input logic [7:0] b);
        case (b[7:6])
            2'b00:   return 4;
            2'b10:   return 3;
            2'b01:   return 2;
            default: return 5;
        endcase
    endfunction

    function automatic int b_act(input logic [7:0] t);
        int a;
        a = (t[7:4] == 4'd0) ? 16 : int'(t[7:4]);
        if (a < 2) a = 2;
        return a;
    endfunction

    function automatic int b_rec(input logic [7:0] t, input logic [1:0] rv);
        int r;
        r = (t[3:0] == 4'd0) ? 16 : int'(t[3:0]);
        if (b_act(t) > 3 && t[3:0] == 4'd1) r = 2;
        if (rv > 2'd1) r = r + 1;
        return r;
    endfunction

    // Driver: waits for idle, presents one request, queues the expectation
    task automatic issue(input int drv, input bit wr, input int wd, input bit noise);
        exp_t       e;
        logic [7:0] sb, tb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        case (drv)
            0:       begin sb = st0;  tb = rw0;  end
            1:       begin sb = st1;  tb = rw1;  end
            default: begin sb = st23; tb = rw23; end
        endcase
        e.s  = b_setup(sb);
        e.a  = b_act(tb);
        e.r  = b_rec(tb, rev);
        e.wr = wr;
        e.wd = wd & 32'hFFFF;
        e.id = next_id;
        next_id++;
        exp_q.push_back(e);
        req_drive = 2'(drv);
        req_write = wr;
        req_wdata = DW'(wd);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            // R7: requests while busy must be ignored
            @(negedge clk);
            req_drive = ~req_drive;
            req_write = ~wr;
            req_wdata = 16'hDEAD;
            req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: measures each cycle's phases and compares at done
    int m_s = 0, m_a = 0, m_r = 0, m_lat = 0;
    bit m_seen = 0, m_oe_bad = 0, m_wd_bad = 0, m_dir_bad = 0, m_idle_bad = 0;
    int m_last_din = 0;

    always @(negedge clk) begin
        if (!rst && mon_on) begin
            if (!req_ready) begin
                if (done) m_idle_bad = 1'b1;
                if (!dior_n || !diow_n) begin
                    m_a++;
                    m_seen = 1'b1;
                    m_last_din = int'(dd_in);
                    if (exp_q.size() > 0) begin
                        if (exp_q[0].wr ? (!dior_n || diow_n) : (!diow_n || dior_n))
                            m_dir_bad = 1'b1;
                    end
                end else if (!m_seen) begin
                    m_s++;
                end else begin
                    m_r++;
                end
                if (rd_latch) begin
                    m_lat++;
                    if (dior_n) m_dir_bad = 1'b1;
                end
                if (exp_q.size() > 0) begin
                    if (wr_oe !== exp_q[0].wr) m_oe_bad = 1'b1;
                    if (exp_q[0].wr && int'(wr_data) != exp_q[0].wd) m_wd_bad = 1'b1;
                end
            end else begin
                if (wr_oe || !dior_n || !diow_n || rd_latch) m_idle_bad = 1'b1;
                if (done) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "done with nothing outstanding", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(m_s == e.s, "R1", $sformatf("txn %0d setup clocks", e.id), m_s, e.s);
                        chk(m_a == e.a, "R2/R3", $sformatf("txn %0d active clocks", e.id), m_a, e.a);
                        chk(m_r == e.r, "R4/R5", $sformatf("txn %0d recovery clocks", e.id), m_r, e.r);
                        chk(!m_dir_bad, "R8/R9", $sformatf("txn %0d strobe direction", e.id), int'(m_dir_bad), 0);
                        chk(!m_idle_bad, "R7", $sformatf("txn %0d idle/done framing", e.id), int'(m_idle_bad), 0);
                        if (e.wr) begin
                            chk(!m_oe_bad, "R9", $sformatf("txn %0d wr_oe span", e.id), int'(m_oe_bad), 0);
                            chk(!m_wd_bad, "R9", $sformatf("txn %0d wr_data", e.id), int'(m_wd_bad), 0);
                            chk(m_lat == 0, "R8", $sformatf("txn %0d rd_latch on write", e.id), m_lat, 0);
                        end else begin
                            chk(!m_oe_bad, "R9", $sformatf("txn %0d wr_oe on read", e.id), int'(m_oe_bad), 0);
                            chk(m_lat == 1, "R8", $sformatf("txn %0d rd_latch pulses", e.id), m_lat, 1);
                            chk(int'(rd_data) == m_last_din, "R8", $sformatf("txn %0d rd_data", e.id),
                                int'(rd_data), m_last_din);
                        end
                    end
                    m_s = 0; m_a = 0; m_r = 0; m_lat = 0;
                    m_seen = 0; m_oe_bad = 0; m_wd_bad = 0; m_dir_bad = 0; m_idle_bad = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(req_ready === 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);
        chk(dior_n === 1'b1 && diow_n === 1'b1, "R11", "strobes after reset",
            int'({dior_n, diow_n}), 3);
        chk(wr_oe === 1'b0 && done === 1'b0 && rd_latch === 1'b0, "R11",
            "oe/done/latch after reset", int'({wr_oe, done, rd_latch}), 0);
        mon_on = 1'b1;

        // R1 R2 R4: code 00 -> 4, zero nibbles -> 16/16
        rev = 2'd1; st0 = 8'h00; rw0 = 8'h00;
        issue(0, 1'b0, 0, 1'b0);
        // R1 R10: code 10 -> 3 with junk low bits; R9 write, recovery nibble 1 kept
        st1 = 8'hBF; rw1 = 8'h21;
        issue(1, 1'b1, 16'hA5C3, 1'b0);
        // R3: active nibble 1 behaves as 2; R1 code 01 -> 2
        st23 = 8'h40; rw23 = 8'h11;
        issue(2, 1'b0, 0, 1'b0);
        // R4: active 4 with recovery nibble 1 -> 2; R1 code 11 -> 5; R10 low bits
        st23 = 8'hC5; rw23 = 8'h41;
        issue(3, 1'b1, 16'h0F0F, 1'b0);
        // R4 boundary: active 3 keeps recovery 1; R10 low bits all set
        st0 = 8'h3F; rw0 = 8'h31;
        issue(0, 1'b0, 0, 1'b0);
        // R5: revision 2 adds a recovery clock
        rev = 2'd2; st1 = 8'h80; rw1 = 8'h35;
        issue(1, 1'b1, 16'h1234, 1'b1);
        // R5: revision 3 with recovery 16 -> 17
        rev = 2'd3; st23 = 8'h00; rw23 = 8'h00;
        issue(2, 1'b0, 0, 1'b1);
        // R6: distinct bytes per register set; drives 2 and 3 share one
        rev = 2'd0;
        st0 = 8'hC0; rw0 = 8'h92; st1 = 8'h40; rw1 = 8'h23; st23 = 8'h80; rw23 = 8'h57;
        issue(3, 1'b0, 0, 1'b0);
        issue(2, 1'b1, 16'h5A5A, 1'b0);
        issue(0, 1'b1, 16'hBEEF, 1'b0);
        issue(1, 1'b0, 0, 1'b0);
        // R7: back-to-back with busy-time noise
        st0 = 8'h40; rw0 = 8'h22;
        issue(0, 1'b1, 16'h7777, 1'b1);
        issue(0, 1'b0, 0, 1'b1);
        issue(0, 1'b1, 16'h8888, 1'b0);

        for (int k = 0; k < 200 && exp_q.size() > 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "outstanding expectations at end", exp_q.size(), 0);
        summary();
    end

endmodule